// File: doc/BRIEF.md
# Sequential Double-Width Multiply/Divide Unit

This unit multiplies two 32-bit words into a 64-bit product, or divides a 64-bit dividend by a 32-bit divisor, one bit per clock. The dividend and the product live in a high:low word pair. After a divide the high word holds the remainder and the low word holds the quotient. The caller pulses `start` with an operation code and operands. `busy` then stays high until `done` pulses for one cycle with the results, the write enables and the flags valid. The result registers keep their values until the next operation completes.

Operation codes on `op` are: 0 unsigned multiply, 1 signed multiply, 2 short signed multiply, 3 unsigned divide, 4 signed divide. Codes 5 to 7 behave like code 0. `src` carries the multiplicand or the divisor. `lo_in` carries the multiplier. `hi_in:lo_in` carries the dividend.

An illegal divide does not produce results. It raises `fault` together with `done`. A divide is illegal when the divisor is zero or when the quotient does not fit the destination. Raising the exception itself is left to the surrounding logic.

Top module: `muldiv_seq`

## Requirements
- R1: Unsigned multiply (op 0, and unused codes 5 to 7) returns `src*lo_in` as a 64-bit product with bits 63:32 on `hi_out` and bits 31:0 on `lo_out`. `wr_hi` and `wr_lo` are both 1. `carry` and `ovf` are both 1 exactly when the high word is nonzero.
- R2: Signed multiply (op 1) treats both operands as two's complement and returns the full 64-bit product. `carry` and `ovf` are both 1 exactly when `hi_out` differs from 32 copies of bit 31 of `lo_out`.
- R3: Short signed multiply (op 2) returns the low 32 bits of the signed product on `lo_out` with `wr_lo`=1 and `wr_hi`=0. Its flags follow the R2 rule applied to the full product.
- R4: Unsigned divide (op 3) puts the quotient of `{hi_in,lo_in}/src` on `lo_out` and the remainder on `hi_out`. `wr_hi`, `wr_lo`, `fault`, `carry` and `ovf` are 1, 1, 0, 0 and 0.
- R5: Signed divide (op 4) truncates the quotient toward zero. The remainder takes the sign of the dividend.
- R6: A zero divisor raises `fault` with `done` one cycle after the start cycle. On a fault `wr_hi`=`wr_lo`=0 and both result words are 0.
- R7: A quotient whose magnitude is at least 2^32 raises `fault` one cycle after the start cycle. A signed quotient below -2^31 or above 2^31-1 that does not meet that condition raises `fault` at the normal completion time.
- R8: `busy` rises the cycle after `start` is sampled. Every operation not faulted early completes with a one-cycle `done` pulse 33 cycles after the start cycle, and `busy` is low when `done` is high.
- R9: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own results and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 3 | Operation code |
| src | input | 32 | Multiplicand or divisor |
| hi_in | input | 32 | High word of the dividend |
| lo_in | input | 32 | Multiplier, or low word of the dividend |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Illegal divide, valid with done |
| wr_hi | output | 1 | High word should be written |
| wr_lo | output | 1 | Low word should be written |
| hi_out | output | 32 | Product high word or remainder |
| lo_out | output | 32 | Product low word or quotient |
| carry | output | 1 | Multiply result exceeds the low word |
| ovf | output | 1 | Same condition as carry for multiply |

## Verification
The bench covers these corner cases and what a faulty design would do on each:
- Negative operands in every sign combination, including -2^31 times -2^31. A design that mixed up magnitude and sign recovery would return a wrong high word.
- Signed divides with a negative dividend or a negative divisor. A design that floored instead of truncating, or that gave the remainder the divisor's sign, would be off by one in the quotient.
- The signed quotient that lands exactly on 2^31, which must fault, and exactly on -2^31, which must not. A range check off by one would swap these outcomes.
- The largest dividend that cannot divide, which must fault early, and the short multiply, which must keep `wr_hi` low. A restart while busy must leave the first operation's results in place.

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  output logic         busy,
  output logic         done,
  output logic         fault,
  output logic         wr_hi,
  output logic         wr_lo,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out,
  output logic         carry,
  output logic         ovf
);
  localparam int CW = $clog2(W);
  localparam int DW = 2 * W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic [DW-1:0] p;
  logic [W-1:0]  m;
  logic [CW-1:0] cnt;
  logic is_div, sgn, short_f, neg_q, neg_r, pre_fault;

  wire go      = start && (st == S_IDLE);
  wire div_in  = (op == 3'd3) || (op == 3'd4);
  wire sgn_in  = (op == 3'd1) || (op == 3'd2) || (op == 3'd4);
  wire shrt_in = (op == 3'd2);

  wire [W-1:0]  a_mag   = (sgn_in && src[W-1])   ? -src   : src;
  wire [W-1:0]  b_mag   = (sgn_in && lo_in[W-1]) ? -lo_in : lo_in;
  wire [DW-1:0] dvd     = {hi_in, lo_in};
  wire [DW-1:0] dvd_mag = (sgn_in && hi_in[W-1]) ? -dvd : dvd;

  wire [W:0]    msum    = {1'b0, p[DW-1:W]} + (p[0] ? {1'b0, m} : {(W+1){1'b0}});
  wire [DW-1:0] mul_nx  = {msum, p[W-1:1]};
  wire [W:0]    trial   = {p[DW-1:W], p[W-1]};
  wire          ge      = trial >= {1'b0, m};
  wire [W:0]    diff    = trial - {1'b0, m};
  wire [DW-1:0] div_nx  = {ge ? diff[W-1:0] : trial[W-1:0], p[W-2:0], ge};

  wire [DW-1:0] prod    = neg_q ? -p : p;
  wire [W-1:0]  quo     = neg_q ? -p[W-1:0] : p[W-1:0];
  wire [W-1:0]  rem     = neg_r ? -p[DW-1:W] : p[DW-1:W];
  wire          q_bad   = sgn && (neg_q ? (p[W-1:0] > {1'b1, {(W-1){1'b0}}}) : p[W-1]);
  wire          ext_bad = sgn ? (prod[DW-1:W] != {W{prod[W-1]}}) : (prod[DW-1:W] != '0);
  wire          flt     = is_div && (pre_fault || q_bad);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      p <= '0;
      m <= '0;
      cnt <= '0;
      is_div <= 1'b0;
      sgn <= 1'b0;
      short_f <= 1'b0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
      pre_fault <= 1'b0;
      done <= 1'b0;
      fault <= 1'b0;
      wr_hi <= 1'b0;
      wr_lo <= 1'b0;
      hi_out <= '0;
      lo_out <= '0;
      carry <= 1'b0;
      ovf <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          m <= a_mag;
          cnt <= '0;
          is_div <= div_in;
          sgn <= sgn_in;
          short_f <= shrt_in;
          if (div_in) begin
            p <= dvd_mag;
            neg_q <= sgn_in && (hi_in[W-1] ^ src[W-1]);
            neg_r <= sgn_in && hi_in[W-1];
            pre_fault <= (dvd_mag[DW-1:W] >= a_mag);
            st <= (dvd_mag[DW-1:W] >= a_mag) ? S_FIN : S_RUN;
          end else begin
            p <= {{W{1'b0}}, b_mag};
            neg_q <= sgn_in && (src[W-1] ^ lo_in[W-1]);
            neg_r <= 1'b0;
            pre_fault <= 1'b0;
            st <= S_RUN;
          end
        end
        S_RUN: begin
          p <= is_div ? div_nx : mul_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= S_FIN;
        end
        default: begin
          st <= S_IDLE;
          done <= 1'b1;
          fault <= flt;
          wr_lo <= !flt;
          wr_hi <= !flt && !short_f;
          hi_out <= flt ? '0 : (is_div ? rem : prod[DW-1:W]);
          lo_out <= flt ? '0 : (is_div ? quo : prod[W-1:0]);
          carry <= !is_div && ext_bad;
          ovf <= !is_div && ext_bad;
        end
      endcase
    end
  end
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic fault,
  input logic wr_hi,
  input logic wr_lo,
  input logic carry,
  input logic ovf
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  assert_fault_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n) (done && fault) |-> (!wr_hi && !wr_lo));
  assert_ok_writes_low_R4: assert property (@(posedge clk) disable iff (!rst_n) (done && !fault) |-> wr_lo);
  assert_restart_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || done));
  assert_flags_match_R1: assert property (@(posedge clk) disable iff (!rst_n) done |-> (carry == ovf));
endmodule

bind muldiv_seq muldiv_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fault(fault), .wr_hi(wr_hi), .wr_lo(wr_lo), .carry(carry), .ovf(ovf)
);

// File: tb/muldiv_seq_bench.sv
module muldiv_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [31:0] src = '0, hi_in = '0, lo_in = '0;
  logic busy, done, fault, wr_hi, wr_lo, carry, ovf;
  logic [31:0] hi_out, lo_out;

  always #10 clk = ~clk;

  muldiv_seq u_muldiv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src(src),
    .hi_in(hi_in), .lo_in(lo_in), .busy(busy), .done(done), .fault(fault),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .hi_out(hi_out), .lo_out(lo_out),
    .carry(carry), .ovf(ovf)
  );

  typedef struct {
    string       rq;
    logic [31:0] hi, lo;
    logic        f, wh, wl, fl;
    int          lat, sc;
  } item_t;

  item_t sb[$];
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check("R9", "unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.rq, "latency", cyc - it.sc, it.lat);
        check(it.rq, "fault", fault, it.f);
        check(it.rq, "wr_hi", wr_hi, it.wh);
        check(it.rq, "wr_lo", wr_lo, it.wl);
        check(it.rq, "carry", carry, it.fl);
        check(it.rq, "ovf", ovf, it.fl);
        check(it.rq, "lo", lo_out, it.lo);
        if (it.wh || it.f) check(it.rq, "hi", hi_out, it.hi);
      end
    end
  end

  task automatic launch(string rq, logic [2:0] o, logic [31:0] s, logic [31:0] h, logic [31:0] l);
    item_t it;
    logic signed [65:0] x, y, pr, q, r, qa;
    bit sg;
    sg = (o == 3'd1) || (o == 3'd2) || (o == 3'd4);
    it.rq = rq; it.f = 0; it.wh = 1; it.wl = 1; it.fl = 0; it.lat = 33;
    if (o == 3'd3 || o == 3'd4) begin
      x = sg ? {{2{h[31]}}, h, l} : {2'b00, h, l};
      y = sg ? {{34{s[31]}}, s} : {34'd0, s};
      if (y == 0) begin
        it.f = 1; it.lat = 1;
      end else begin
        q = x / y;
        r = x % y;
        qa = (q < 0) ? -q : q;
        if (qa >= 66'sd4294967296) begin
          it.f = 1; it.lat = 1;
        end else if (sg && (q > 66'sd2147483647 || q < -66'sd2147483648)) begin
          it.f = 1;
        end
        it.lo = q[31:0];
        it.hi = r[31:0];
      end
      if (it.f) begin
        it.wh = 0; it.wl = 0; it.lo = '0; it.hi = '0;
      end
    end else begin
      x = sg ? {{34{s[31]}}, s} : {34'd0, s};
      y = sg ? {{34{l[31]}}, l} : {34'd0, l};
      pr = x * y;
      it.hi = pr[63:32];
      it.lo = pr[31:0];
      it.fl = sg ? (pr[63:31] != '0 && pr[63:31] != '1) : (pr[63:32] != '0);
      if (o == 3'd2) it.wh = 0;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    op = o; src = s; hi_in = h; lo_in = l; start = 1'b1;
    it.sc = cyc + 1;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(string rq, logic [2:0] o, logic [31:0] s, logic [31:0] h, logic [31:0] l);
    launch(rq, o, s, h, l);
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "busy in reset", busy, 0);
    check("R8", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "busy idle", busy, 0);

    run("R1", 3'd0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);
    run("R1", 3'd0, 32'd3, 32'h0, 32'd5);
    run("R1", 3'd0, 32'h0001_0000, 32'h0, 32'h0001_0000);
    run("R1", 3'd6, 32'h8000_0001, 32'h0, 32'd4);
    run("R2", 3'd1, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF);
    run("R2", 3'd1, 32'hFFFF_FFFE, 32'h0, 32'd3);
    run("R2", 3'd1, 32'h8000_0000, 32'h0, 32'h8000_0000);
    run("R2", 3'd1, 32'h7FFF_FFFF, 32'h0, 32'd2);
    run("R2", 3'd1, 32'h1234_5678, 32'h0, 32'hEDCB_A988);
    run("R3", 3'd2, 32'hFFFF_FFF9, 32'h0, 32'd6);
    run("R3", 3'd2, 32'h0001_0000, 32'h0, 32'h0001_0000);
    run("R4", 3'd3, 32'd2, 32'd1, 32'd0);
    run("R4", 3'd3, 32'd7, 32'd0, 32'd100);
    run("R4", 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    run("R5", 3'd4, 32'd2, 32'hFFFF_FFFF, 32'hFFFF_FFF9);
    run("R5", 3'd4, 32'hFFFF_FFFE, 32'd0, 32'd7);
    run("R5", 3'd4, 32'hFFFF_FFFD, 32'hFFFF_FFFF, 32'hFFFF_FFF0);
    run("R5", 3'd4, 32'd1, 32'hFFFF_FFFF, 32'h8000_0000);
    run("R6", 3'd3, 32'd0, 32'd0, 32'd9);
    run("R6", 3'd4, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R7", 3'd3, 32'd5, 32'd5, 32'd0);
    run("R7", 3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000);
    run("R7", 3'd4, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0);
    run("R7", 3'd4, 32'd1, 32'h0000_0000, 32'h8000_0000);

    launch("R9", 3'd0, 32'd11, 32'h0, 32'd13);
    repeat (5) @(negedge clk);
    op = 3'd3; src = 32'd0; hi_in = 32'd1; lo_in = 32'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    check("R9", "busy after ignored start", busy, 0);
    check("R9", "result kept", {hi_out, lo_out}, 64'd143);

    finish_run();
  end
endmodule